// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level and Idle Timeout

This block is the receive-side queue of a serial port. It takes characters and line-break events from the receive deserialiser, holds up to sixteen of them, and gives them back one at a time when the host reads the receive buffer. It also produces the receive-side status the host polls: data ready, break seen and overrun. It reports the current fill level and a trigger flag that goes high once the fill level reaches a threshold the host picks. A small idle detector flags data that has sat in the queue for four character times without a read, so that a driver waiting on the trigger level still collects the tail of a short message.

The host controls the block through writes to the FIFO control byte. With queueing switched off, the block behaves as a single receive holding register. The length of one character time is worked out inside the block from the line format (data length, parity, stop bits) and a per-bit tick supplied by the baud generator.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: After reset, `data_ready`, `break_flag`, `overrun`, `timeout_pend`, `trig_hit` and `fifo_on` are 0, `fifo_level` is 0 and `rbr_data` reads 0x00.
- R2: With queueing on (control bit 0 = 1), received bytes come out on `rbr_data` in arrival order, one per `rbr_rd` pulse, and `fifo_level` follows the number held.
- R3: A byte or break arriving while 16 bytes are held is discarded, the held bytes are kept unchanged and `overrun` is set. If a read occurs in the same cycle, the read is taken first, the new byte is stored and `overrun` is not set.
- R4: Control bits 7:6 pick the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. With queueing on, `trig_hit` is 1 exactly when `fifo_level` is at or above the threshold.
- R5: A break event stores a 0x00 byte and sets both `break_flag` and `data_ready`.
- R6: Each received byte, and each read that leaves bytes behind, restarts a four-character-time idle window. When the window runs out while the queue holds data, `timeout_pend` is set; it is not set if the queue is empty.
- R7: A receive-buffer read clears `timeout_pend`. A read that empties the queue also clears `data_ready` and `break_flag`. A read of an empty queue returns 0x00.
- R8: A control write with bit 1 set empties the queue, clears `data_ready`, `break_flag` and `timeout_pend`, and stops the idle window.
- R9: A control write that changes bit 0 performs the receive reset of R8 and raises `tx_flush`. `tx_flush` is also raised by a control write with bit 2 set; it is high during the write cycle only.
- R10: With queueing off, the block holds one byte: `rbr_data` shows the last byte received, a byte arriving while `data_ready` is 1 replaces it and sets `overrun`, and `trig_hit` equals `data_ready`.
- R11: A pulse on `lsr_rd` clears `break_flag` and `overrun`.
- R12: One character time is 1 + (`frame_cfg`[1:0] + 5) + `frame_cfg`[3] + (1 + `frame_cfg`[2]) bit ticks. The idle window of R6 therefore ends on the 4×that-many-th `bit_tick` after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | A line break was detected this cycle |
| bit_tick | input | 1 | One pulse per serial bit time |
| frame_cfg | input | 4 | Line format: [1:0] data length − 5, [2] two stop bits, [3] parity present |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_data | input | 8 | FIFO control value: [0] queue on, [1] receive reset, [2] transmit reset, [7:6] trigger select |
| rbr_rd | input | 1 | Host reads the receive buffer this cycle |
| lsr_rd | input | 1 | Host reads the line status this cycle |
| rbr_data | output | 8 | Byte returned by a receive-buffer read |
| data_ready | output | 1 | Receive data available |
| break_flag | output | 1 | Break received |
| overrun | output | 1 | Data was lost |
| fifo_level | output | 5 | Bytes held in the queue |
| trig_hit | output | 1 | Fill level at or above the trigger threshold |
| timeout_pend | output | 1 | Idle timeout pending |
| fifo_on | output | 1 | Queueing currently enabled |
| tx_flush | output | 1 | Request to the transmit side to empty its queue |

## Verification
The bench fills the queue to exactly sixteen bytes and then sends one more. A design that overwrote or shifted the stored data on overrun would break the read-back order, and one that accepted the extra byte would report a level of 17. It then applies a push and a read in the same cycle on a full queue: an implementation that checked fullness before popping would drop the byte and set overrun. The idle window is sampled one bit tick before and exactly at its end, for three line formats. An off-by-one in the frame length or the character count shifts the flag by a tick, and a window that ignored the empty condition raises a flag after the queue has been drained. Control writes are checked for trigger changes that must not flush the queue, and for enable flips that must flush it.

// File: rtl/rxq_pkg.sv
// Shared types and helpers for the receive queue.
// Assumes the queue depth is at least the largest trigger threshold (14).
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'b00,
        TRIG_FOUR = 2'b01,
        TRIG_EGHT = 2'b10,
        TRIG_FRTN = 2'b11
    } trig_sel_e;

    // Map the trigger select field to a byte threshold.
    function automatic int trig_threshold(trig_sel_e sel);
        case (sel)
            TRIG_ONE:  return 1;
            TRIG_FOUR: return 4;
            TRIG_EGHT: return 8;
            default:   return 14;
        endcase
    endfunction

    // Bits per character: start + data + optional parity + stop.
    function automatic int frame_bits(logic [3:0] cfg);
        return 1 + (int'(cfg[1:0]) + 5) + int'(cfg[3]) + (cfg[2] ? 2 : 1);
    endfunction

endpackage

// File: rtl/rxq_ring.sv
// Circular byte store with occupancy count.
// A pop is applied before a push, so a full store accepts a push when a pop
// happens in the same cycle. A push that cannot be stored raises drop.
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             drop
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (rst_n && !clr && do_push) mem[wr_ptr] <= din;
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !clr |=> full && $stable(rd_ptr));

endmodule

// File: rtl/rxq_char_clock.sv
// Turns per-bit ticks into one pulse per character time for the line format
// in cfg. Restart zeroes the bit count so the next character begins fresh.
module rxq_char_clock #(
    parameter int FBW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       bit_tick,
    input  logic [3:0] cfg,
    output logic       char_tick
);
    import rxq_pkg::*;

    logic [FBW-1:0] bit_cnt;
    logic [FBW-1:0] fbits;

    assign fbits     = FBW'(frame_bits(cfg));
    assign char_tick = bit_tick && !restart && (bit_cnt >= fbits - 1'b1);

    // Count bit ticks within the current character.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) bit_cnt <= '0;
        else if (bit_tick)     bit_cnt <= char_tick ? '0 : bit_cnt + 1'b1;
    end

    assert_char_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(char_tick) |-> bit_cnt == '0);

endmodule

// File: rtl/rxq_idle_timer.sv
// Counts CHARS character ticks after a restart and pulses expire on the last.
// Halt stops it and wins over restart; it stays idle until the next restart.
module rxq_idle_timer #(
    parameter int CHARS = 4,
    localparam int TW = $clog2(CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic halt,
    input  logic char_tick,
    output logic expire
);

    logic          run;
    logic [TW-1:0] cnt;

    assign expire = run && !restart && !halt && char_tick && (cnt == TW'(CHARS - 1));

    // Window state: idle, or running with a count of elapsed characters.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (restart) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run && char_tick) begin
            run <= !expire;
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < TW'(CHARS));

endmodule

// File: rtl/uart_rx_fifo_ctl.sv
// Receive queue control for a serial port: status flags, trigger level,
// idle timeout and the single-register mode used when queueing is off.
// Assumes rx_valid/rx_break are single-cycle events from the deserialiser
// (break wins if both), and host read strobes are one cycle per access.
module uart_rx_fifo_ctl #(
    parameter int DEPTH         = 16,
    parameter int TIMEOUT_CHARS = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_break,
    input  logic          bit_tick,
    input  logic [3:0]    frame_cfg,
    input  logic          fcr_wr,
    input  logic [7:0]    fcr_data,
    input  logic          rbr_rd,
    input  logic          lsr_rd,
    output logic [7:0]    rbr_data,
    output logic          data_ready,
    output logic          break_flag,
    output logic          overrun,
    output logic [CW-1:0] fifo_level,
    output logic          trig_hit,
    output logic          timeout_pend,
    output logic          fifo_on,
    output logic          tx_flush
);
    import rxq_pkg::*;

    trig_sel_e     trig_q;
    logic [7:0]    hold_q;
    logic [7:0]    ring_head, in_byte;
    logic          ring_full, ring_empty, ring_drop;
    logic          en_flip, rx_flush, rx_in;
    logic          q_push, q_pop, last_read, win_restart, win_halt;
    logic          char_tick, expire;
    logic [CW-1:0] thresh;
    logic          unused_bits;

    assign unused_bits = ^{fcr_data[5:3], ring_full, ring_empty};

    assign en_flip  = fcr_wr && (fcr_data[0] != fifo_on);
    assign rx_flush = fcr_wr && (fcr_data[1] || en_flip);
    assign tx_flush = fcr_wr && (fcr_data[2] || en_flip);
    assign rx_in    = rx_valid || rx_break;
    assign in_byte  = rx_break ? 8'h00 : rx_data;
    assign q_push   = fifo_on && rx_in && !rx_flush;
    assign q_pop    = fifo_on && rbr_rd && !rx_flush;
    // A read that leaves nothing behind (single-register mode always does).
    assign last_read   = rbr_rd && (!fifo_on || fifo_level <= CW'(1));
    assign win_halt    = rx_flush || !fifo_on;
    assign win_restart = q_push || (q_pop && fifo_level > CW'(1));
    assign thresh      = CW'(trig_threshold(trig_q));
    assign trig_hit    = fifo_on ? (fifo_level >= thresh) : data_ready;
    assign rbr_data    = fifo_on ? ring_head : hold_q;

    rxq_ring #(.DEPTH(DEPTH), .WIDTH(8)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_flush),
        .push  (q_push),
        .pop   (q_pop),
        .din   (in_byte),
        .head  (ring_head),
        .count (fifo_level),
        .full  (ring_full),
        .empty (ring_empty),
        .drop  (ring_drop)
    );

    rxq_char_clock #(.FBW(4)) u_char (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (win_restart),
        .bit_tick  (bit_tick),
        .cfg       (frame_cfg),
        .char_tick (char_tick)
    );

    rxq_idle_timer #(.CHARS(TIMEOUT_CHARS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (win_restart),
        .halt      (win_halt),
        .char_tick (char_tick),
        .expire    (expire)
    );

    // Control register: queue enable and trigger select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_on <= 1'b0;
            trig_q  <= TRIG_ONE;
        end else if (fcr_wr) begin
            fifo_on <= fcr_data[0];
            trig_q  <= trig_sel_e'(fcr_data[7:6]);
        end
    end

    // Single holding register used while queueing is off.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 hold_q <= 8'h00;
        else if (!fifo_on && rx_in && !rx_flush)    hold_q <= in_byte;
    end

    // Data-ready and break flags; a new arrival wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush) begin
            data_ready <= 1'b0;
            break_flag <= 1'b0;
        end else begin
            data_ready <= rx_in || (data_ready && !last_read);
            break_flag <= rx_break || (break_flag && !last_read && !lsr_rd);
        end
    end

    // Overrun: queue drop, or a new byte over an unread holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else begin
            overrun <= ring_drop
                    || (!fifo_on && rx_in && !rx_flush && data_ready && !rbr_rd)
                    || (overrun && !lsr_rd);
        end
    end

    // Idle timeout flag: cleared by a read or receive reset, set on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_flush || (fifo_on && rbr_rd)) timeout_pend <= 1'b0;
        else if (expire && fifo_level != '0)         timeout_pend <= 1'b1;
    end

    assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && rbr_rd && fifo_level == CW'(1) && !rx_in && !fcr_wr
        |=> !data_ready && !break_flag);

    assert_timeout_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> fifo_level != '0);

    assert_rx_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_data[1] |=> fifo_level == '0 && !data_ready && !timeout_pend);

    assert_enable_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && (fcr_data[0] != fifo_on) |=> fifo_level == '0 && !data_ready);

    assert_lsr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_in |=> !break_flag && !overrun);

endmodule

// File: tb/uart_rx_fifo_ctl_tb.sv
// Scoreboard bench: driver tasks queue expected bytes, a monitor compares
// every receive-buffer read against the queue while queueing is on.
module uart_rx_fifo_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_break = 1'b0, bit_tick = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [3:0] frame_cfg = 4'b0011;
    logic       fcr_wr = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
    logic [7:0] fcr_data = 8'h00;
    logic [7:0] rbr_data;
    logic       data_ready, break_flag, overrun, trig_hit, timeout_pend, fifo_on, tx_flush;
    logic [4:0] fifo_level;

    int         n_chk = 0, n_bad = 0;
    bit         sb_on = 1'b0, done = 1'b0;
    string      sb_req = "R2";
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    uart_rx_fifo_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .bit_tick(bit_tick), .frame_cfg(frame_cfg),
        .fcr_wr(fcr_wr), .fcr_data(fcr_data), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
        .rbr_data(rbr_data), .data_ready(data_ready), .break_flag(break_flag),
        .overrun(overrun), .fifo_level(fifo_level), .trig_hit(trig_hit),
        .timeout_pend(timeout_pend), .fifo_on(fifo_on), .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        tick();
        rx_valid = 1'b0;
        if (exp_q.size() < 16) exp_q.push_back(b);
    endtask

    task automatic push_brk();
        rx_break = 1'b1;
        tick();
        rx_break = 1'b0;
        if (exp_q.size() < 16) exp_q.push_back(8'h00);
    endtask

    task automatic rd();
        rbr_rd = 1'b1;
        tick();
        rbr_rd = 1'b0;
    endtask

    task automatic push_rd(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; rbr_rd = 1'b1;
        tick();
        rx_valid = 1'b0; rbr_rd = 1'b0;
        exp_q.push_back(b);
    endtask

    task automatic lsr();
        lsr_rd = 1'b1;
        tick();
        lsr_rd = 1'b0;
    endtask

    task automatic fcr(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_data = v;
        tick();
        fcr_wr = 1'b0;
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            tick();
        end
        bit_tick = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: every read in queue mode must return the oldest expected byte.
    always @(negedge clk) begin
        if (rst_n && sb_on && rbr_rd) begin
            if (exp_q.size() > 0) chk(sb_req, rbr_data, exp_q.pop_front());
            else                  chk("R7", rbr_data, 8'h00);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", {data_ready, break_flag, overrun, timeout_pend, trig_hit, fifo_on}, 6'b0);
        chk("R1", fifo_level, 0);
        chk("R1", rbr_data, 8'h00);

        // R10 single-register mode
        push(8'h41);
        chk("R10", {data_ready, trig_hit}, 2'b11);
        chk("R10", rbr_data, 8'h41);
        push(8'h42);
        chk("R10", overrun, 1);
        chk("R10", rbr_data, 8'h42);
        lsr();
        chk("R11", overrun, 0);
        rd();
        chk("R10", {data_ready, trig_hit}, 2'b00);
        exp_q.delete();

        // R9 enabling queue flips bit 0
        fcr_wr = 1'b1; fcr_data = 8'h01;
        #1 chk("R9", tx_flush, 1);
        tick();
        fcr_wr = 1'b0;
        chk("R9", {fifo_on, tx_flush}, 2'b10);
        chk("R9", fifo_level, 0);
        sb_on = 1'b1;

        // R2 order and level
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        chk("R2", fifo_level, 5);
        chk("R4", trig_hit, 1);
        rd(); rd();
        chk("R2", fifo_level, 3);
        rd(); rd(); rd();
        chk("R7", {data_ready, fifo_level}, 6'b0);
        rd();   // empty read returns 0x00 (R7)

        // R4 trigger thresholds
        fcr(8'h41);
        chk("R4", fifo_level, 0);
        push(8'h20); push(8'h21); push(8'h22);
        chk("R4", trig_hit, 0);
        push(8'h23);
        chk("R4", trig_hit, 1);
        fcr(8'h81);
        chk("R4", {trig_hit, fifo_level}, 6'd4);
        for (int i = 0; i < 4; i++) push(8'h30 + 8'(i));
        chk("R4", trig_hit, 1);
        fcr(8'hC1);
        chk("R4", trig_hit, 0);
        for (int i = 0; i < 5; i++) push(8'h40 + 8'(i));
        chk("R4", {trig_hit, fifo_level}, 6'd13);
        push(8'h50);
        chk("R4", {trig_hit, fifo_level}, {1'b1, 5'd14});

        // R3 full and overrun
        push(8'h51); push(8'h52);
        chk("R3", {overrun, fifo_level}, {1'b0, 5'd16});
        push(8'hEE);
        chk("R3", {overrun, fifo_level}, {1'b1, 5'd16});
        lsr();
        chk("R11", overrun, 0);
        sb_req = "R3";
        push_rd(8'h77);
        chk("R3", {overrun, fifo_level}, {1'b0, 5'd16});
        for (int i = 0; i < 16; i++) rd();
        chk("R3", fifo_level, 0);
        sb_req = "R2";

        // R5 break
        push_brk();
        chk("R5", {data_ready, break_flag, fifo_level}, {2'b11, 5'd1});
        sb_req = "R5";
        rd();
        chk("R7", {data_ready, break_flag}, 2'b00);
        push(8'h55); push_brk();
        lsr();
        chk("R11", {break_flag, data_ready}, 2'b01);
        rd(); rd();
        sb_req = "R2";

        // R6 / R12 idle window, 10-bit frame
        fcr(8'h01);
        frame_cfg = 4'b0011;
        push(8'h99);
        bits(39);
        chk("R12", timeout_pend, 0);
        bits(1);
        chk("R6", timeout_pend, 1);
        rd();
        chk("R7", timeout_pend, 0);
        bits(40);
        chk("R6", timeout_pend, 0);
        // 12-bit frame
        frame_cfg = 4'b1111;
        push(8'hA1); push(8'hA2);
        bits(47);
        chk("R12", timeout_pend, 0);
        bits(1);
        chk("R12", timeout_pend, 1);
        rd();
        chk("R7", timeout_pend, 0);
        bits(47);
        chk("R6", timeout_pend, 0);
        bits(1);
        chk("R6", timeout_pend, 1);
        rd();
        // 7-bit frame
        frame_cfg = 4'b0000;
        push(8'hB0);
        bits(27);
        chk("R12", timeout_pend, 0);
        bits(1);
        chk("R12", timeout_pend, 1);
        rd();

        // R8 receive reset
        frame_cfg = 4'b0011;
        push(8'hC0); push(8'hC1); push(8'hC2);
        bits(40);
        chk("R8", timeout_pend, 1);
        fcr(8'hC3);
        exp_q.delete();
        chk("R8", {data_ready, timeout_pend, fifo_level}, 7'b0);
        chk("R8", fifo_on, 1);
        bits(40);
        chk("R8", timeout_pend, 0);

        // R9 transmit-only reset, then disabling flushes
        push(8'hD0); push(8'hD1);
        fcr_wr = 1'b1; fcr_data = 8'hC5;
        #1 chk("R9", tx_flush, 1);
        tick();
        fcr_wr = 1'b0;
        chk("R9", fifo_level, 2);
        sb_on = 1'b0;
        fcr_wr = 1'b1; fcr_data = 8'h00;
        #1 chk("R9", tx_flush, 1);
        tick();
        fcr_wr = 1'b0;
        exp_q.delete();
        chk("R9", {fifo_on, data_ready, fifo_level}, 7'b0);

        tick();
        report();
    end

endmodule